// File: doc/BRIEF.md
# Programmable Three-Counter Interval Timer

This block holds three 16-bit periodic down-counters behind a byte-wide register port. Software first writes a control byte that picks a counter and its divisor access style: low byte only, high byte only, or low byte then high byte. It then writes the divisor one byte at a time. When the divisor is complete, the counter is armed. From then on it counts down once per prescaler tick. When it expires, it reloads itself and emits a one-cycle terminal-count pulse.

Counter 1 is the system clock source. Its gate is always open. Its expiry raises a sticky clock-interrupt request, unless the timer-inhibit input is high. Reading a dedicated acknowledge word returns zero and drops that request.

The register port is a plain strobe interface with word addresses:

| Word (`reg_word`) | Function |
|---|---|
| 0, 1, 2 | Divisor of counters 0, 1 and 2 |
| 3 | Control |
| 4 | Interrupt acknowledge |
| 5, 6, 7 | Unmapped |

Read data comes back one cycle after the read strobe, marked by `rd_valid`. The port has no back-pressure, and reads and writes are never issued in the same cycle.

Top module: `interval_timer3`

## Requirements
- R1: A write to word 3 takes the counter number from data bits 7:6. For counters 0, 1 and 2, the write stores the whole byte as that counter's mode, disarms the counter and resets its byte toggle. A value of 3 in bits 7:6 makes the write have no effect.
- R2: Mode bits 5:4 give the access style: 01 low byte only, 10 high byte only, 11 low then high. With 00, divisor writes are ignored and divisor reads return 0.
- R3: In low-only or high-only style, a divisor write replaces that byte and keeps the other byte. It arms the counter and loads the count with the new divisor.
- R4: In low-then-high style, the first divisor write loads the low byte and sets the toggle. The second write loads the high byte, clears the toggle, arms the counter and loads the count.
- R5: In low-then-high style, a divisor read returns the low byte when the toggle is clear and the high byte when it is set, and it inverts the toggle. Reads and writes share this one toggle.
- R6: A divisor read returns the running count when the counter is armed and its gate is high. Otherwise it returns the programmed divisor.
- R7: A read of word 3 returns the mode byte of the counter named by the last accepted control write (counter 0 after reset).
- R8: An armed counter with its gate high decrements on each cycle with `tick_en` high. On the tick where the count is 1, it reloads the divisor and pulses its `tc` bit high for exactly the next cycle. A divisor of 0 gives a period of 65536 ticks.
- R9: Counter 1 counts whatever the gate inputs are; only counters 0 and 2 have gate pins.
- R10: `clk_irq` is set in the cycle after `tc[1]` is high while `timer_inhibit` is low. It then stays high until it is acknowledged. A pulse of `tc[1]` while the inhibit is high does not set it.
- R11: A read of word 4 returns 0 and clears `clk_irq`. If a `tc[1]` set event falls in the same cycle, the set wins.
- R12: Read data and `rd_valid` are registered one cycle after `rd_en`. Reads of words 5 to 7 return 0. A synchronous reset clears every mode, divisor, count, arm flag, toggle, `tc`, `clk_irq` and the read outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Prescaler tick, one decrement per high cycle |
| gate0_in | input | 1 | Gate of counter 0 |
| gate2_in | input | 1 | Gate of counter 2 |
| timer_inhibit | input | 1 | Blocks setting of the clock interrupt |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_word | input | 3 | Register word address |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| tc | output | 3 | Terminal-count pulses, one bit per counter |
| clk_irq | output | 1 | Sticky clock-interrupt request |

## Verification
The checker watches several rules on every cycle:
- `clk_irq` rises only after a `tc[1]` pulse taken with the inhibit low.
- `clk_irq` falls only after an acknowledge read, and an acknowledge with no competing set leaves it low.
- An acknowledge read returns zero.
- A terminal-count pulse always follows a tick.
- `rd_valid` always follows a read strobe.

Other behaviours need directed scenarios with known expected bytes:
- how the toggle sequences divisor bytes across mixed reads and writes;
- the switch from divisor to running count on a read;
- disarming by a control write, and the ignored counter-select value 3;
- the 65536-tick period of a zero divisor.

// File: rtl/timer3_pkg.sv
package timer3_pkg;
  localparam int NUM_CTR = 3;
  localparam int CLK_CTR = 1;
  localparam int WORD_W = 3;
  localparam int SEL_W = 2;
  localparam logic [WORD_W-1:0] CTL_WORD = 3'd3;
  localparam logic [WORD_W-1:0] CLR_WORD = 3'd4;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_LOHI = 2'b11
  } acc_e;
endpackage

// File: rtl/timer3_chan.sv
module timer3_chan
  import timer3_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              gate,
  input  logic              ctl_wr,
  input  logic              div_wr,
  input  logic              div_rd,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] mode_o,
  output logic [BYTE_W-1:0] rd_byte_o,
  output logic              tc_o
);
  localparam int DW = 2 * BYTE_W;

  logic [DW-1:0] div_q, cnt_q, view;
  logic          en_q, tog_q;
  acc_e          acc;

  assign acc  = acc_e'(mode_o[5:4]);
  assign view = (en_q && gate) ? cnt_q : div_q;

  // byte that a read of this divisor would return now
  always_comb begin
    unique case (acc)
      ACC_LO:   rd_byte_o = view[BYTE_W-1:0];
      ACC_HI:   rd_byte_o = view[DW-1:BYTE_W];
      ACC_LOHI: rd_byte_o = tog_q ? view[DW-1:BYTE_W] : view[BYTE_W-1:0];
      default:  rd_byte_o = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o <= '0;
      div_q  <= '0;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      tog_q  <= 1'b0;
      tc_o   <= 1'b0;
    end else begin
      tc_o <= 1'b0;
      if (en_q && gate && tick_en) begin
        if (cnt_q == DW'(1)) begin
          cnt_q <= div_q;
          tc_o  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;  // 0 wraps: period 2**DW
        end
      end
      if (ctl_wr) begin
        mode_o <= din;
        en_q   <= 1'b0;
        tog_q  <= 1'b0;
      end else if (div_wr) begin
        unique case (acc)
          ACC_LO: begin
            div_q[BYTE_W-1:0] <= din;
            cnt_q <= {div_q[DW-1:BYTE_W], din};
            en_q  <= 1'b1;
          end
          ACC_HI: begin
            div_q[DW-1:BYTE_W] <= din;
            cnt_q <= {din, div_q[BYTE_W-1:0]};
            en_q  <= 1'b1;
          end
          ACC_LOHI: begin
            if (!tog_q) begin
              div_q[BYTE_W-1:0] <= din;
              tog_q <= 1'b1;
            end else begin
              div_q[DW-1:BYTE_W] <= din;
              cnt_q <= {din, div_q[BYTE_W-1:0]};
              tog_q <= 1'b0;
              en_q  <= 1'b1;
            end
          end
          default: ;
        endcase
      end else if (div_rd && acc == ACC_LOHI) begin
        tog_q <= ~tog_q;
      end
    end
  end
endmodule

// File: rtl/timer3_irq.sv
module timer3_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (rst)        irq_o <= 1'b0;
    else if (set_i) irq_o <= 1'b1;  // a new event beats an acknowledge
    else if (clr_i) irq_o <= 1'b0;
  end
endmodule

// File: rtl/interval_timer3.sv
module interval_timer3
  import timer3_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic               gate0_in,
  input  logic               gate2_in,
  input  logic               timer_inhibit,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [WORD_W-1:0]  reg_word,
  input  logic [BYTE_W-1:0]  wr_data,
  output logic [BYTE_W-1:0]  rd_data,
  output logic               rd_valid,
  output logic [NUM_CTR-1:0] tc,
  output logic               clk_irq
);
  localparam int SEL_LSB = BYTE_W - SEL_W;

  logic [SEL_W-1:0]  ctl_sel, last_sel_q;
  logic              is_div, is_ctl, is_clr, ctl_ok;
  logic [NUM_CTR-1:0] gate_v;
  logic [BYTE_W-1:0] mode_a  [NUM_CTR];
  logic [BYTE_W-1:0] rbyte_a [NUM_CTR];
  logic [BYTE_W-1:0] rd_next;

  assign is_div  = (reg_word < WORD_W'(NUM_CTR));
  assign is_ctl  = (reg_word == CTL_WORD);
  assign is_clr  = (reg_word == CLR_WORD);
  assign ctl_sel = wr_data[BYTE_W-1:SEL_LSB];
  assign ctl_ok  = wr_en && is_ctl && (32'(ctl_sel) < NUM_CTR);

  always_comb begin
    gate_v          = '1;
    gate_v[0]       = gate0_in;
    gate_v[2]       = gate2_in;
    gate_v[CLK_CTR] = 1'b1;  // clock counter is never gated off
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic hit;
    assign hit = is_div && (reg_word[SEL_W-1:0] == SEL_W'(i));
    timer3_chan #(.BYTE_W(BYTE_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .tick_en   (tick_en),
      .gate      (gate_v[i]),
      .ctl_wr    (ctl_ok && (ctl_sel == SEL_W'(i))),
      .div_wr    (wr_en && hit),
      .div_rd    (rd_en && hit),
      .din       (wr_data),
      .mode_o    (mode_a[i]),
      .rd_byte_o (rbyte_a[i]),
      .tc_o      (tc[i])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (is_div && reg_word[SEL_W-1:0] == SEL_W'(i)) rd_next = rbyte_a[i];
      if (is_ctl && last_sel_q == SEL_W'(i))          rd_next = mode_a[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      rd_valid   <= 1'b0;
      last_sel_q <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en)  rd_data    <= rd_next;
      if (ctl_ok) last_sel_q <= ctl_sel;
    end
  end

  timer3_irq u_irq (
    .clk   (clk),
    .rst   (rst),
    .set_i (tc[CLK_CTR] && !timer_inhibit),
    .clr_i (rd_en && is_clr),
    .irq_o (clk_irq)
  );
endmodule

// File: rtl/timer3_chk.sv
module timer3_chk
  import timer3_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               tick_en,
  input logic               timer_inhibit,
  input logic               rd_en,
  input logic [WORD_W-1:0]  reg_word,
  input logic [BYTE_W-1:0]  rd_data,
  input logic               rd_valid,
  input logic [NUM_CTR-1:0] tc,
  input logic               clk_irq
);
  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_irq) |-> $past(tc[CLK_CTR] && !timer_inhibit));

  assert_irq_fall_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_irq) |-> $past(rd_en && reg_word == CLR_WORD));

  assert_irq_ack_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_word == CLR_WORD && !(tc[CLK_CTR] && !timer_inhibit)) |=> !clk_irq);

  assert_ack_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_word == CLR_WORD) |=> (rd_data == '0));

  assert_tc_tick_R8: assert property (@(posedge clk) disable iff (rst)
    (|tc) |-> $past(tick_en));

  assert_rd_valid_R12: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));
endmodule

bind interval_timer3 timer3_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .tick_en       (tick_en),
  .timer_inhibit (timer_inhibit),
  .rd_en         (rd_en),
  .reg_word      (reg_word),
  .rd_data       (rd_data),
  .rd_valid      (rd_valid),
  .tc            (tc),
  .clk_irq       (clk_irq)
);

// File: tb/interval_timer3_tb_top.sv
module interval_timer3_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 0, gate0_in = 0, gate2_in = 0, timer_inhibit = 0;
  logic       wr_en = 0, rd_en = 0;
  logic [2:0] reg_word = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic [2:0] tc;
  logic       clk_irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  always #10 clk = ~clk;  // 50 MHz

  interval_timer3 dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .gate0_in(gate0_in),
    .gate2_in(gate2_in), .timer_inhibit(timer_inhibit), .wr_en(wr_en),
    .rd_en(rd_en), .reg_word(reg_word), .wr_data(wr_data),
    .rd_data(rd_data), .rd_valid(rd_valid), .tc(tc), .clk_irq(clk_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] w, input logic [7:0] d);
    reg_word = w; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: pushes the expected byte, the monitor pops it
  task automatic rd(input logic [2:0] w, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    reg_word = w; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12 unexpected read data actual=%0h expected=none", rd_data);
      end else begin
        chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R12 watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    cyc(3);
    rst = 1'b0;
    chk("R12 reset rd_data", rd_data, 0);
    chk("R12 reset rd_valid", rd_valid, 0);
    chk("R12 reset tc", tc, 0);
    chk("R12 reset clk_irq", clk_irq, 0);
    rd(3'd3, 8'h00, "R7 control after reset");
    rd(3'd0, 8'h00, "R12 divisor after reset");

    // counter 0, low then high, gate 0 low
    wr(3'd3, 8'h30);
    rd(3'd3, 8'h30, "R1 mode stored");
    wr(3'd0, 8'h05);
    wr(3'd0, 8'h00);
    rd(3'd0, 8'h05, "R4 low byte");
    rd(3'd0, 8'h00, "R5 high byte second");
    tick(2);
    rd(3'd0, 8'h05, "R6 gate low keeps divisor");
    rd(3'd0, 8'h00, "R6 gate low high byte");
    gate0_in = 1'b1;
    tick(2);
    rd(3'd0, 8'h03, "R6 running count low");
    rd(3'd0, 8'h00, "R6 running count high");
    wr(3'd0, 8'h07);  // first write sets the toggle
    rd(3'd0, 8'h00, "R5 shared toggle gives high byte");
    rd(3'd0, 8'h03, "R5 toggle flipped back to low");
    gate0_in = 1'b0;
    wr(3'd3, 8'h30);
    rd(3'd0, 8'h07, "R1 control write disarms counter");

    // counter 1, low only, divisor 3
    wr(3'd3, 8'h50);
    wr(3'd1, 8'h03);
    tick(2);
    chk("R8 no tc before expiry", tc, 3'b000);
    tick(1);
    chk("R9 counter1 counts with gates low", tc, 3'b010);
    chk("R10 irq one cycle after tc", clk_irq, 0);
    cyc(1);
    chk("R8 tc is one cycle", tc, 3'b000);
    chk("R10 irq set", clk_irq, 1);
    cyc(3);
    chk("R10 irq sticky", clk_irq, 1);
    rd(3'd4, 8'h00, "R11 ack reads zero");
    chk("R11 ack clears irq", clk_irq, 0);

    // high only keeps low byte
    wr(3'd3, 8'h60);
    wr(3'd1, 8'h02);
    rd(3'd1, 8'h02, "R3 high byte written");
    wr(3'd3, 8'h50);
    rd(3'd1, 8'h03, "R3 low byte kept");

    // access style 00
    wr(3'd3, 8'h40);
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'h00, "R2 style 00 reads zero");
    wr(3'd3, 8'h50);
    rd(3'd1, 8'h03, "R2 style 00 write ignored");

    // divisor 1 and inhibit
    wr(3'd3, 8'h70);
    wr(3'd1, 8'h01);
    wr(3'd1, 8'h00);
    timer_inhibit = 1'b1;
    tick(1);
    chk("R8 divisor 1 expires each tick", tc, 3'b010);
    cyc(1);
    chk("R10 inhibit blocks irq", clk_irq, 0);
    tick(1);
    chk("R8 divisor 1 again", tc, 3'b010);
    timer_inhibit = 1'b0;
    tick(1);
    cyc(1);
    chk("R10 irq after inhibit released", clk_irq, 1);
    rd(3'd4, 8'h00, "R11 ack zero");
    chk("R11 cleared", clk_irq, 0);
    tick(1);  // tc[1] high during the next cycle
    rd(3'd4, 8'h00, "R11 ack during set");
    chk("R11 set wins over ack", clk_irq, 1);
    rd(3'd4, 8'h00, "R11 final ack");
    chk("R11 cleared again", clk_irq, 0);
    rd(3'd5, 8'h00, "R12 unmapped word");

    // select value 3 ignored
    wr(3'd3, 8'hF0);
    rd(3'd3, 8'h70, "R1 select 3 ignored mode");
    tick(1);
    chk("R1 select 3 did not disarm", tc, 3'b010);
    wr(3'd3, 8'hA1);
    rd(3'd3, 8'hA1, "R7 control reads last selected");
    wr(3'd2, 8'h01);
    rd(3'd2, 8'h01, "R3 counter2 high only");

    // divisor 0 gives 65536 ticks
    timer_inhibit = 1'b1;
    wr(3'd3, 8'h70);
    wr(3'd1, 8'h00);
    wr(3'd1, 8'h00);
    tick_en = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tc[1] && n < 70000);
    tick_en = 1'b0;
    chk("R8 divisor 0 period", n, 65536);

    cyc(3);
    chk("R12 all reads returned", exp_q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule